// File: doc/BRIEF.md
# Video ID CRC Word Inserter

This block produces the 20-bit identification word that a 525-line composite encoder places in the vertical blanking interval. The word carries the aspect-ratio and copy-generation information. Fourteen payload bits come from two configuration inputs. A 6-bit CRC is appended to them. The result is sent serially, first bit first, on two fixed lines of each frame.

The timing block supplies the pixel count and the line count. At a fixed pixel the inserter opens an output window. It then steps through the 20 bits with a phase accumulator, so the bit period can be a fractional number of clocks and still average out correctly. For each bit the level-select output chooses the high level (a 1) or blanking (a 0). The window output tells the downstream mixer that this line belongs to the identification word, so it takes priority over any other blanking-interval signalling on that line.

New configuration values are captured only on the falling edge of the vertical sync input. The CRC is then computed serially, one bit per clock, and the finished word replaces the one being transmitted. This block has no streaming data path. All pins are plain control and timing signals, and there is no back-pressure.

Top module: `vid_id_inserter`

## Requirements
- R1: After reset, window_o and level_o are 0. Until the first vsync falling edge, the transmitted word is all zeros.
- R2: Payload order is fixed. Send bits 1..6 are id_hi_i[5] down to id_hi_i[0]. Send bits 7..14 are id_lo_i[7] down to id_lo_i[0].
- R3: Send bits 15..20 are a CRC over send bits 1..14. The CRC is taken in send order with generator x^6+x+1 and register preset to 6'b111111. At each step fb = data ^ crc[5], the register shifts left, and fb is XORed into positions 0 and 1. The final register is sent crc[5] first.
- R4: If h_cnt_i equals START_PIX (275) at a clock edge on line 20 or 283 while enabled, window_o is 1 from that edge onward.
- R5: After the k-th edge following the start edge (the start edge counts as k=0), level_o shows send bit n+1, where n = floor(k*PH_STEP/2^16) and PH_STEP is 1195.
- R6: window_o falls at the first edge where k*PH_STEP >= 20*2^16. level_o is 1 only inside the window, and only for a 1 bit.
- R7: On any line other than 20 and 283, no window opens.
- R8: No window opens while pal_mode_i is 1 or id_en_i is 0. Both are sampled at the start edge.
- R9: A change on id_hi_i or id_lo_i has no effect until the next vsync_i falling edge. Until then the previous word keeps being sent.
- R10: The transmitted word does not change while a window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_mode_i | input | 1 | Video standard select, 0 for 525-line |
| id_en_i | input | 1 | Identification word enable |
| id_hi_i | input | 6 | Payload send bits 1..6 |
| id_lo_i | input | 8 | Payload send bits 7..14 |
| vsync_i | input | 1 | Vertical sync, latch on falling edge |
| h_cnt_i | input | 11 | Pixel count within line from timing block |
| v_line_i | input | 10 | Line number from timing block |
| window_o | output | 1 | Identification window active, overrides other signalling |
| level_o | output | 1 | 1 selects high level, 0 selects blanking |

## Verification
The hardest condition to reach is the fractional bit-boundary pattern. The clock at which a bit changes drifts by a fraction of a clock from bit to bit, so a wrong accumulator step or a wrong boundary compare shows up only at a few clocks in the whole line. The bench therefore compares both outputs on every clock of every encoded line, for several payload patterns. It predicts each bit edge arithmetically from the step value. It also stages register changes without a vsync between two lines, to show that the old word stays in place.

// File: rtl/vid_id_pkg.sv
package vid_id_pkg;
  localparam int WORD_BITS = 20;
  localparam int DATA_BITS = 14;
  localparam int CRC_BITS  = 6;
  localparam logic [CRC_BITS-1:0] CRC_TAPS = 6'b000011;
  localparam logic [CRC_BITS-1:0] CRC_SEED = 6'b111111;
endpackage

// File: rtl/vid_id_crc.sv
module vid_id_crc
  import vid_id_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] data,
  input  logic                 hold,
  output logic [CRC_BITS-1:0]  crc,
  output logic                 done
);
  localparam int CNT_W = $clog2(DATA_BITS + 1);

  logic [DATA_BITS-1:0] shreg;
  logic [CNT_W-1:0]     left;
  logic                 fb;
  logic [CRC_BITS-1:0]  crc_nx;

  always_comb begin
    fb     = shreg[DATA_BITS-1] ^ crc[CRC_BITS-1];
    crc_nx = {crc[CRC_BITS-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      crc   <= CRC_SEED;
      left  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        shreg <= data;
        crc   <= CRC_SEED;
        left  <= CNT_W'(DATA_BITS);
      end else if (left != '0 && !hold) begin
        shreg <= {shreg[DATA_BITS-2:0], 1'b0};
        crc   <= crc_nx;
        left  <= left - 1'b1;
        if (left == CNT_W'(1)) done <= 1'b1;
      end
    end
  end

  // R3: the step counter never exceeds the payload length
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    left <= CNT_W'(DATA_BITS));
  // R3: completion follows a step taken from a count of one
  a_r3_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> left == '0);
endmodule

// File: rtl/vid_id_bit_timer.sv
module vid_id_bit_timer #(
  parameter int WORD_BITS = 20,
  parameter int PH_W      = 16,
  parameter int PH_STEP   = 1195
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  output logic                            active,
  output logic [$clog2(WORD_BITS+1)-1:0]  bit_idx
);
  localparam int IDX_W = $clog2(WORD_BITS + 1);
  localparam int POS_W = IDX_W + PH_W;

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] pos_nx;
  logic             last;

  always_comb begin
    pos_nx = pos + POS_W'(PH_STEP);
    last   = pos_nx[POS_W-1:PH_W] >= IDX_W'(WORD_BITS);
  end

  assign bit_idx = pos[POS_W-1:PH_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      active <= 1'b0;
    end else if (start) begin
      pos    <= '0;
      active <= 1'b1;
    end else if (active) begin
      pos <= pos_nx;
      if (last) active <= 1'b0;
    end
  end

  // R5: the bit index advances by at most one per clock inside a window
  a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(start)) |->
      (bit_idx == $past(bit_idx) || bit_idx == $past(bit_idx) + 1'b1));
  // R6: the index stays inside the word while the window is open
  a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> bit_idx < IDX_W'(WORD_BITS));
endmodule

// File: rtl/vid_id_inserter.sv
module vid_id_inserter
  import vid_id_pkg::*;
#(
  parameter int H_W       = 11,
  parameter int V_W       = 10,
  parameter int START_PIX = 275,
  parameter int LINE_A    = 20,
  parameter int LINE_B    = 283,
  parameter int PH_W      = 16,
  parameter int PH_STEP   = 1195
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pal_mode_i,
  input  logic           id_en_i,
  input  logic [5:0]     id_hi_i,
  input  logic [7:0]     id_lo_i,
  input  logic           vsync_i,
  input  logic [H_W-1:0] h_cnt_i,
  input  logic [V_W-1:0] v_line_i,
  output logic           window_o,
  output logic           level_o
);
  localparam int IDX_W = $clog2(WORD_BITS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BITS - 1);

  logic                 vs_q;
  logic                 vs_fall;
  logic [DATA_BITS-1:0] shadow;
  logic [WORD_BITS-1:0] tx_word;
  logic [CRC_BITS-1:0]  crc;
  logic                 crc_done;
  logic                 enabled;
  logic                 line_hit;
  logic                 start;
  logic                 active;
  logic [IDX_W-1:0]     bit_idx;
  logic [IDX_W-1:0]     sel;

  always_comb begin
    vs_fall  = vs_q && !vsync_i;
    enabled  = !pal_mode_i && id_en_i;
    line_hit = (v_line_i == V_W'(LINE_A)) || (v_line_i == V_W'(LINE_B));
    start    = enabled && line_hit && (h_cnt_i == H_W'(START_PIX)) && !active;
    sel      = LAST_IDX - bit_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q    <= 1'b1;
      shadow  <= '0;
      tx_word <= '0;
    end else begin
      vs_q <= vsync_i;
      if (vs_fall) shadow <= {id_hi_i, id_lo_i};
      if (crc_done) tx_word <= {shadow, crc};
    end
  end

  vid_id_crc u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .load (vs_fall),
    .data ({id_hi_i, id_lo_i}),
    .hold (active || start),
    .crc  (crc),
    .done (crc_done)
  );

  vid_id_bit_timer #(
    .WORD_BITS(WORD_BITS),
    .PH_W     (PH_W),
    .PH_STEP  (PH_STEP)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .active (active),
    .bit_idx(bit_idx)
  );

  assign window_o = active;
  assign level_o  = active && tx_word[sel];

  // R6: high level only inside the window
  a_r6_level_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    level_o |-> window_o);
  // R7 R8: a window opens only after an enabled edge on an encoded line
  a_r7_open_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window_o) |-> $past(enabled && line_hit));
  // R10: the word under transmission is frozen
  a_r10_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (window_o && $past(window_o)) |-> $stable(tx_word));
endmodule

// File: tb/vid_id_inserter_tb_top.sv
module vid_id_inserter_tb_top;
  localparam int CLK_NS    = 40;
  localparam int START_PIX = 275;
  localparam int PH_STEP   = 1195;
  localparam int LINE_CLKS = 1500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pal_mode_i = 1'b0;
  logic        id_en_i = 1'b1;
  logic [5:0]  id_hi_i = '0;
  logic [7:0]  id_lo_i = '0;
  logic        vsync_i = 1'b1;
  logic [10:0] h_cnt_i = '0;
  logic [9:0]  v_line_i = '0;
  logic        window_o, level_o;

  int vectors = 0;
  int fails = 0;
  logic [19:0] exp_word = '0;

  always #(CLK_NS/2) clk = ~clk;

  vid_id_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .pal_mode_i(pal_mode_i), .id_en_i(id_en_i),
    .id_hi_i(id_hi_i), .id_lo_i(id_lo_i), .vsync_i(vsync_i),
    .h_cnt_i(h_cnt_i), .v_line_i(v_line_i),
    .window_o(window_o), .level_o(level_o)
  );

  function automatic logic [19:0] make_word(input logic [5:0] hi, input logic [7:0] lo);
    logic [13:0] d;
    logic [5:0]  c;
    logic        fb;
    d = {hi, lo};
    c = 6'b111111;
    for (int i = 13; i >= 0; i--) begin
      fb = d[i] ^ c[5];
      c  = {c[4:0], 1'b0};
      if (fb) c = c ^ 6'b000011;
    end
    return {d, c};
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_vsync();
    @(negedge clk); vsync_i = 1'b0;
    repeat (3) @(negedge clk);
    vsync_i = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  // runs one line and compares every clock; enc tells whether a word is expected
  task automatic run_line(input int line, input bit enc, input string req);
    int k;
    logic ew, el;
    @(negedge clk);
    v_line_i = 10'(line);
    for (int h = 0; h <= LINE_CLKS; h++) begin
      @(negedge clk);
      if (h > 0) begin
        k  = h - 1 - START_PIX;
        ew = enc && k >= 0 && (k * PH_STEP) < (20 * 65536);
        el = ew && exp_word[19 - ((k * PH_STEP) >>> 16)];
        check({req, " window"}, window_o, ew);
        check({req, " level"}, level_o, el);
      end
      if (h < LINE_CLKS) h_cnt_i = 11'(h);
    end
    h_cnt_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset window", window_o, 1'b0);
    check("R1 reset level", level_o, 1'b0);
    rst_n = 1'b1;
    // R1: zero word before any vsync, window still framed (R4 R6)
    exp_word = '0;
    run_line(20, 1'b1, "R1 R4 R6 zero word");
    // R2 R3 R5: several payload patterns
    id_hi_i = 6'h3F; id_lo_i = 8'hFF; pulse_vsync();
    exp_word = make_word(6'h3F, 8'hFF);
    run_line(20, 1'b1, "R2 R3 R5 ones line20");
    id_hi_i = 6'h2A; id_lo_i = 8'h55; pulse_vsync();
    exp_word = make_word(6'h2A, 8'h55);
    run_line(283, 1'b1, "R2 R3 R5 alt line283");
    id_hi_i = 6'h01; id_lo_i = 8'h80; pulse_vsync();
    exp_word = make_word(6'h01, 8'h80);
    run_line(20, 1'b1, "R2 R3 single bits");
    id_hi_i = 6'h00; id_lo_i = 8'h00; pulse_vsync();
    exp_word = make_word(6'h00, 8'h00);
    run_line(283, 1'b1, "R3 zero payload");
    // R9: change without vsync keeps old word
    id_hi_i = 6'h15; id_lo_i = 8'hC3;
    run_line(20, 1'b1, "R9 old word kept");
    pulse_vsync();
    exp_word = make_word(6'h15, 8'hC3);
    run_line(20, 1'b1, "R9 new word after vsync");
    // R7: other lines
    run_line(21, 1'b0, "R7 line21");
    run_line(19, 1'b0, "R7 line19");
    // R8: disabled cases
    pal_mode_i = 1'b1;
    run_line(20, 1'b0, "R8 pal mode");
    pal_mode_i = 1'b0; id_en_i = 1'b0;
    run_line(283, 1'b0, "R8 enable off");
    id_en_i = 1'b1;
    // R10: word stays constant across a whole window after re-enable
    run_line(283, 1'b1, "R10 re-enabled");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule